// File: doc/BRIEF.md
# Banked Cartridge Controller with Infrared Port

This block sits between a CPU bus and a cartridge's ROM and RAM. CPU writes into the ROM address space are decoded into two bank registers and one mode flag. The low bank register supplies the upper bits of the switchable ROM window address. The high bank register supplies the upper bits of the RAM window address.

The range that many controllers use as a RAM enable here selects an infrared mode instead. With that mode off, every access to the RAM window (0xA000 to 0xBFFF) goes to the external RAM, and no enable flag gates writes. With the mode on, the window stops reaching RAM and acts as a one-bit infrared port. A write drives the cartridge LED. A read returns a fixed pattern with a light-sense bit in bit 0.

Each LED transition produces a one-cycle event. The event carries the new level and the number of clock cycles since the previous transition. That count saturates at its maximum.

Top module: `ircart_ctrl`

## Requirements
- R1: After reset both bank registers are zero, infrared mode is off, `ir_led` is 0 and `ir_evt` is 0.
- R2: A write to 0x0000–0x1FFF turns infrared mode on when data bits 3:0 equal 0xE, and turns it off for any other value.
- R3: A write to 0x2000–0x3FFF loads the data byte into the low bank. A ROM access with address bit 14 set then yields `rom_addr` = {low bank, address bits 13:0}. With bit 14 clear, the bank field of `rom_addr` is zero.
- R4: A write to 0x4000–0x5FFF loads the data byte into the high bank, and `ram_addr` = {high bank, address bits 12:0}.
- R5: A write to 0x6000–0x7FFF changes neither bank register nor the mode.
- R6: In infrared mode, a read of 0xA000–0xBFFF returns 0xC0 with bit 0 set to (`ir_led` OR `ir_rx` OR `host_led`), and bits 5:1 zero.
- R7: In infrared mode, a write to the RAM window sets `ir_led` to data bit 0 at the next clock edge and keeps `ram_cs` and `ram_we` low.
- R8: A write that changes `ir_led` raises `ir_evt` for exactly one cycle in the same cycle as the LED change. The event carries `ir_evt_level` equal to the new level and `ir_evt_cycles` equal to the clock edges since the previous change. A write that leaves the LED unchanged raises no event.
- R9: Outside infrared mode, a write to the RAM window raises `ram_cs` and `ram_we` in the same cycle, with no enable flag required, and leaves `ir_led` unchanged.
- R10: Outside infrared mode, a read of the RAM window raises `ram_cs` with `ram_we` low and returns `ram_rdata`. With `RAM_FITTED` = 0 it returns 0xFF and `ram_cs` stays low.
- R11: The cycle count saturates at 2^CNT_W−1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe, sampled at the clock edge |
| cpu_rdata | output | 8 | Read data for the RAM window (combinational) |
| rom_addr | output | BANK_W+14 | Banked ROM address |
| ram_addr | output | BANK_W+13 | Banked RAM address |
| ram_cs | output | 1 | External RAM chip select |
| ram_we | output | 1 | External RAM write enable |
| ram_rdata | input | 8 | External RAM read data |
| host_led | input | 1 | LED bit of the host's own infrared port |
| ir_rx | input | 1 | Infrared receiver level |
| ir_led | output | 1 | Cartridge infrared LED |
| ir_evt | output | 1 | One-cycle LED change event |
| ir_evt_level | output | 1 | New LED level carried by the event |
| ir_evt_cycles | output | CNT_W | Cycles since the previous LED change |

## Verification
The assertions assume that `cpu_wr` is a single-cycle pulse held stable across the edge that samples it. They also assume that `cpu_rd` and `cpu_wr` are never high together, so the RAM strobes and the read pattern stay unambiguous. The stimulus changes bus signals only on the falling clock edge and issues each access as one isolated strobe. The LED-change timing is measured from edge numbers that the bench counts itself. The saturation case is reached by building the bench with a 6-bit counter.

// File: rtl/ircart_pkg.sv
package ircart_pkg;

    typedef enum logic [2:0] {
        RG_MODE,
        RG_BANK_LO,
        RG_BANK_HI,
        RG_SPARE,
        RG_RAM,
        RG_OTHER
    } region_t;

    function automatic region_t decode_region(input logic [15:0] addr);
        case (addr[15:13])
            3'b000:  return RG_MODE;
            3'b001:  return RG_BANK_LO;
            3'b010:  return RG_BANK_HI;
            3'b011:  return RG_SPARE;
            3'b101:  return RG_RAM;
            default: return RG_OTHER;
        endcase
    endfunction

    localparam logic [3:0] IR_KEY = 4'hE;

endpackage

// File: rtl/ircart_regs.sv
module ircart_regs
    import ircart_pkg::*;
#(
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  region_t           region,
    input  logic [7:0]        wdata,
    output logic              mode,
    output logic [BANK_W-1:0] bank_lo,
    output logic [BANK_W-1:0] bank_hi
);

    typedef struct packed {
        logic              mode;
        logic [BANK_W-1:0] lo;
        logic [BANK_W-1:0] hi;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr) begin
            case (region)
                RG_MODE:    s_d.mode = (wdata[3:0] == IR_KEY);
                RG_BANK_LO: s_d.lo   = wdata[BANK_W-1:0];
                RG_BANK_HI: s_d.hi   = wdata[BANK_W-1:0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mode    = s_q.mode;
    assign bank_lo = s_q.lo;
    assign bank_hi = s_q.hi;

    // R5
    spare_noeffect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && region == RG_SPARE) |=> ($stable(mode) && $stable(bank_lo) && $stable(bank_hi)));

endmodule

// File: rtl/ircart_ir.sv
module ircart_ir #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ir_wr,
    input  logic             ir_bit,
    output logic             led,
    output logic             evt,
    output logic             evt_level,
    output logic [CNT_W-1:0] evt_cycles
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic             led;
        logic             evt;
        logic             lvl;
        logic [CNT_W-1:0] cyc;
        logic [CNT_W-1:0] cnt;
    } ir_t;

    ir_t  s_d, s_q;
    logic change;

    always_comb begin
        s_d     = s_q;
        s_d.evt = 1'b0;
        change  = ir_wr && (ir_bit != s_q.led);
        if (change) begin
            s_d.led = ir_bit;
            s_d.evt = 1'b1;
            s_d.lvl = ir_bit;
            s_d.cyc = s_q.cnt;
            s_d.cnt = CNT_ONE;
        end else if (s_q.cnt != CNT_MAX) begin
            s_d.cnt = s_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign led        = s_q.led;
    assign evt        = s_q.evt;
    assign evt_level  = s_q.lvl;
    assign evt_cycles = s_q.cyc;

    // R11
    cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == CNT_MAX && !change) |=> (s_q.cnt == CNT_MAX));

    // R8
    led_change_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (led != $past(led)) |-> evt);

    // R8
    evt_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> (evt_level == led));

endmodule

// File: rtl/ircart_rdmux.sv
module ircart_rdmux
    import ircart_pkg::*;
#(
    parameter bit RAM_FITTED = 1'b1
) (
    input  region_t    region,
    input  logic       rd,
    input  logic       wr,
    input  logic       mode,
    input  logic [7:0] ram_rdata,
    input  logic       led,
    input  logic       rx,
    input  logic       host_led,
    output logic [7:0] rdata,
    output logic       cs,
    output logic       we
);

    logic in_win;

    always_comb begin
        in_win = (region == RG_RAM);
        cs     = RAM_FITTED && in_win && !mode && (rd || wr);
        we     = cs && wr;
        rdata  = 8'hFF;
        if (in_win && mode)
            rdata = {2'b11, 5'b00000, led | rx | host_led};
        else if (in_win && RAM_FITTED)
            rdata = ram_rdata;
    end

endmodule

// File: rtl/ircart_ctrl.sv
module ircart_ctrl
    import ircart_pkg::*;
#(
    parameter int BANK_W     = 8,
    parameter int CNT_W      = 16,
    parameter bit RAM_FITTED = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [15:0]         cpu_addr,
    input  logic [7:0]          cpu_wdata,
    input  logic                cpu_rd,
    input  logic                cpu_wr,
    output logic [7:0]          cpu_rdata,
    output logic [BANK_W+13:0]  rom_addr,
    output logic [BANK_W+12:0]  ram_addr,
    output logic                ram_cs,
    output logic                ram_we,
    input  logic [7:0]          ram_rdata,
    input  logic                host_led,
    input  logic                ir_rx,
    output logic                ir_led,
    output logic                ir_evt,
    output logic                ir_evt_level,
    output logic [CNT_W-1:0]    ir_evt_cycles
);

    region_t           region;
    logic              mode;
    logic [BANK_W-1:0] bank_lo, bank_hi;
    logic              ir_wr;

    always_comb begin
        region   = decode_region(cpu_addr);
        ir_wr    = cpu_wr && mode && (region == RG_RAM);
        rom_addr = {(cpu_addr[14] ? bank_lo : {BANK_W{1'b0}}), cpu_addr[13:0]};
        ram_addr = {bank_hi, cpu_addr[12:0]};
    end

    ircart_regs #(.BANK_W(BANK_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cpu_wr),
        .region  (region),
        .wdata   (cpu_wdata),
        .mode    (mode),
        .bank_lo (bank_lo),
        .bank_hi (bank_hi)
    );

    ircart_ir #(.CNT_W(CNT_W)) u_ir (
        .clk        (clk),
        .rst_n      (rst_n),
        .ir_wr      (ir_wr),
        .ir_bit     (cpu_wdata[0]),
        .led        (ir_led),
        .evt        (ir_evt),
        .evt_level  (ir_evt_level),
        .evt_cycles (ir_evt_cycles)
    );

    ircart_rdmux #(.RAM_FITTED(RAM_FITTED)) u_rdmux (
        .region    (region),
        .rd        (cpu_rd),
        .wr        (cpu_wr),
        .mode      (mode),
        .ram_rdata (ram_rdata),
        .led       (ir_led),
        .rx        (ir_rx),
        .host_led  (host_led),
        .rdata     (cpu_rdata),
        .cs        (ram_cs),
        .we        (ram_we)
    );

    // R7
    ir_blocks_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode |-> !ram_cs);

    // R6
    ir_read_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && cpu_rd && region == RG_RAM) |-> (cpu_rdata[7:1] == 7'b1100000));

    // R7
    ir_write_led_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ir_wr |=> (ir_led == $past(cpu_wdata[0])));

    // R9
    plain_write_led_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !mode) |=> $stable(ir_led));

endmodule

// File: tb/tb_ircart_ctrl.sv
module tb_ircart_ctrl;

    localparam int BANK_W = 8;
    localparam int CNT_W  = 6;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0]  ram_rdata = 8'h00;
    logic        host_led = 1'b0, ir_rx = 1'b0;

    logic [7:0]          cpu_rdata, rdata2;
    logic [BANK_W+13:0]  rom_addr, rom_addr2;
    logic [BANK_W+12:0]  ram_addr, ram_addr2;
    logic                ram_cs, ram_we, ram_cs2, ram_we2;
    logic                ir_led, ir_evt, ir_evt_level;
    logic                led2, evt2, lvl2;
    logic [CNT_W-1:0]    ir_evt_cycles, cyc2;

    always #4 clk = ~clk;

    ircart_ctrl #(.BANK_W(BANK_W), .CNT_W(CNT_W), .RAM_FITTED(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
        .rom_addr(rom_addr), .ram_addr(ram_addr), .ram_cs(ram_cs), .ram_we(ram_we),
        .ram_rdata(ram_rdata), .host_led(host_led), .ir_rx(ir_rx), .ir_led(ir_led),
        .ir_evt(ir_evt), .ir_evt_level(ir_evt_level), .ir_evt_cycles(ir_evt_cycles)
    );

    ircart_ctrl #(.BANK_W(BANK_W), .CNT_W(CNT_W), .RAM_FITTED(1'b0)) dut_noram (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(rdata2),
        .rom_addr(rom_addr2), .ram_addr(ram_addr2), .ram_cs(ram_cs2), .ram_we(ram_we2),
        .ram_rdata(ram_rdata), .host_led(host_led), .ir_rx(ir_rx), .ir_led(led2),
        .ir_evt(evt2), .ir_evt_level(lvl2), .ir_evt_cycles(cyc2)
    );

    typedef struct { logic level; int cycles; } evt_item_t;
    evt_item_t exp_q[$];

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int last_chg = 0;
    logic model_led = 1'b0;
    logic model_mode = 1'b0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected events as the design emits them.
    always @(negedge clk) begin
        if (rst_n && !done && ir_evt === 1'b1) begin
            if (exp_q.size() == 0) begin
                check("R8 unexpected event", 32'd1, 32'd0);
            end else begin
                evt_item_t it;
                it = exp_q.pop_front();
                check("R8 event level", {31'd0, ir_evt_level}, {31'd0, it.level});
                check("R8 event cycles", 32'(ir_evt_cycles), 32'(it.cycles));
            end
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        int edge_no, gap;
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        edge_no = cyc + 1;
        if (a[15:13] == 3'b000) model_mode = (d[3:0] == 4'hE);
        if (a[15:13] == 3'b101 && model_mode && d[0] != model_led) begin
            evt_item_t it;
            gap = edge_no - last_chg;
            it.level = d[0];
            it.cycles = (gap > CMAX) ? CMAX : gap;
            exp_q.push_back(it);
            last_chg = edge_no;
            model_led = d[0];
        end
        #1;
        if (a[15:13] == 3'b101) begin
            check(model_mode ? "R7 no cs in ir write" : "R9 cs on write", {31'd0, ram_cs}, {31'd0, !model_mode});
            check(model_mode ? "R7 no we in ir write" : "R9 we on write", {31'd0, ram_we}, {31'd0, !model_mode});
        end
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1;
        check(req, {24'd0, cpu_rdata}, {24'd0, exp});
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        check("watchdog expired", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        last_chg = cyc + 1;
        #1;
        // R1 reset state
        cpu_addr = 16'h4000;
        #1;
        check("R1 low bank zero", 32'(rom_addr), 32'h4000 & 32'h3FFF);
        check("R1 high bank zero", 32'(ram_addr >> 13), 32'd0);
        check("R1 led off", {31'd0, ir_led}, 32'd0);
        check("R1 no event", {31'd0, ir_evt}, 32'd0);
        ram_rdata = 8'h3C;
        rd(16'hA005, 8'h3C, "R1 mode off after reset");

        // R3 low bank
        wr(16'h2000, 8'h5A);
        cpu_addr = 16'h4123; #1;
        check("R3 rom_addr banked", 32'(rom_addr), {10'd0, 8'h5A, 14'h0123});
        cpu_addr = 16'h0123; #1;
        check("R3 bank zero below 0x4000", 32'(rom_addr), 32'h0123);
        wr(16'h3FFF, 8'hA7);
        cpu_addr = 16'h7FFF; #1;
        check("R3 second load", 32'(rom_addr), {10'd0, 8'hA7, 14'h3FFF});

        // R4 high bank
        wr(16'h5FFF, 8'hC3);
        cpu_addr = 16'hA010; #1;
        check("R4 ram_addr banked", 32'(ram_addr), {11'd0, 8'hC3, 13'h0010});

        // R5 spare range has no effect
        wr(16'h6000, 8'hFF);
        wr(16'h7ABC, 8'h0E);
        cpu_addr = 16'h4000; #1;
        check("R5 low bank kept", 32'(rom_addr >> 14), 32'hA7);
        check("R5 high bank kept", 32'(ram_addr >> 13), 32'hC3);
        rd(16'hA000, 8'h3C, "R5 mode kept off");

        // R10 plain read
        @(negedge clk);
        cpu_addr = 16'hB123; cpu_rd = 1'b1; ram_rdata = 8'h96; #1;
        check("R10 ram data", {24'd0, cpu_rdata}, 32'h96);
        check("R10 cs on read", {31'd0, ram_cs}, 32'd1);
        check("R10 no we on read", {31'd0, ram_we}, 32'd0);
        check("R10 not fitted reads FF", {24'd0, rdata2}, 32'hFF);
        check("R10 not fitted no cs", {31'd0, ram_cs2}, 32'd0);
        @(negedge clk); cpu_rd = 1'b0;

        // R9 plain write reaches RAM, LED untouched
        wr(16'hA005, 8'h01);
        idle(1);
        check("R9 led unchanged", {31'd0, ir_led}, 32'd0);

        // R2 infrared mode on
        wr(16'h0000, 8'h1E);
        rd(16'hA000, 8'hC0, "R2 R6 ir read all dark");
        ir_rx = 1'b1;
        rd(16'hA001, 8'hC1, "R6 ir read rx");
        ir_rx = 1'b0; host_led = 1'b1;
        rd(16'hB000, 8'hC1, "R6 ir read host led");
        host_led = 1'b0;

        // R7 R8 LED writes
        wr(16'hA000, 8'h03);
        idle(1);
        check("R7 led on", {31'd0, ir_led}, 32'd1);
        rd(16'hA000, 8'hC1, "R6 ir read own led");
        idle(10);
        wr(16'hB000, 8'hFE);
        idle(1);
        check("R7 led off", {31'd0, ir_led}, 32'd0);
        wr(16'hA000, 8'h00);
        check("R8 no event on unchanged write", {31'd0, ir_evt}, 32'd0);
        idle(2);
        wr(16'hA000, 8'h01);
        idle(1);
        // R11 saturation
        idle(100);
        wr(16'hA000, 8'h00);
        idle(2);

        // R2 mode off with other value, on with E in low nibble
        wr(16'h1000, 8'h0A);
        ram_rdata = 8'h55;
        rd(16'hA000, 8'h55, "R2 mode off");
        wr(16'h1FFF, 8'hEE);
        rd(16'hA000, 8'hC0, "R2 mode on EE");
        wr(16'h0000, 8'hE0);
        rd(16'hA000, 8'h55, "R2 mode off E0");
        idle(3);

        check("R8 all events seen", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule